// File: doc/BRIEF.md
# Segmented K-line Message Sender with Echo Verification

This block sends one diagnostic message over a single-wire, half-duplex K-line serial bus. On such a bus the sender hears everything it transmits, so each byte comes back on the receive side as an echo. A start pulse latches the message length. The block then clears out any bytes already waiting in the receiver. After that it takes the payload bytes from a valid/ready byte stream and passes them to the UART transmitter. Once the last payload byte has gone out, it adds an additive checksum byte.

The message is sent in segments of bounded size. After each segment the block stops transmitting and waits for the same number of echo bytes. It compares each echo with the byte it sent in the same position. A wrong echo byte, or an echo byte that does not arrive in time, sets a sticky error flag and ends the transfer. A single-cycle done pulse marks the end of every transfer, whether it succeeded or was aborted. The bit-level UART logic and the line transceiver sit outside this block.

Top module: `kline_seg_tx`

## Requirements
- R1: After the last payload byte, the block sends one extra byte equal to the sum of all payload bytes modulo 256.
- R2: The frame (payload plus checksum) goes out in segments of 15 bytes each, and the final segment carries the remainder. No segment holds more than 15 bytes.
- R3: After a segment, no further byte is offered to the transmitter until as many echo bytes have been accepted as the segment held.
- R4: An echo byte that differs from the byte sent in the same position sets `echo_err`. The remaining segments are then dropped and `done` still pulses.
- R5: Between an accepted start and the first transmitted byte, the block accepts and discards every byte the receiver already holds.
- R6: Exactly `msg_len` payload bytes are accepted. `in_ready` is never high while echo bytes are being collected or while the checksum is being sent.
- R7: `msg_len` is captured at the accepted start. Later changes on that input have no effect on the running frame.
- R8: `echo_err` stays set after an error until the next accepted start, which clears it.
- R9: If no echo byte is accepted for `echo_timeout` consecutive cycles while echo bytes are awaited, the block sets `echo_err` and aborts. A value of 0 is treated as 1.
- R10: A start pulse while `busy` is high, or with `msg_len` equal to 0, is ignored.
- R11: After reset, `busy`, `done`, `echo_err`, `tx_valid`, `in_ready` and `rx_ready` are all low.
- R12: `done` is high for exactly one cycle at the end of each accepted transfer. `busy` is low from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; accepted only when idle with non-zero `msg_len` |
| msg_len | input | 8 | Payload length in bytes (1 to 255), captured at start |
| echo_timeout | input | 16 | Maximum idle cycles allowed between echo bytes |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Payload byte taken |
| tx_valid | output | 1 | Byte offered to the UART transmitter |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Transmitter accepts the byte |
| rx_valid | input | 1 | Receiver holds a byte |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Block takes the received byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| echo_err | output | 1 | Sticky echo mismatch or timeout flag |

## Verification
The bench targets frame lengths near the 15-byte segment boundary: exactly one full segment, one byte over, and the longest frame. A design that counts segments wrongly would either send a 16th byte before its echoes return or stall waiting for echoes that never come. Echoes are returned as soon as each byte is sent, so a design that starts the next segment early is caught because it sends with echoes still outstanding. Other scenarios cover:
- stale bytes already queued in the receiver, which a design that skips draining would read as wrong echoes;
- a corrupted echo in the first and in the last segment, to check that the abort drops exactly the unsent segments;
- an echo stream that stops partway, plus a very short timeout on a healthy frame, so that a timer off by a cycle in either direction shows up;
- length changes and stray start pulses during a transfer, which a design that does not hold its captured length would act on.

// File: rtl/kline_pkg.sv
package kline_pkg;
   typedef enum logic [2:0] {
      KL_IDLE  = 3'd0,
      KL_DRAIN = 3'd1,
      KL_SEND  = 3'd2,
      KL_ECHO  = 3'd3,
      KL_DONE  = 3'd4
   } kl_state_e;
endpackage

// File: rtl/kline_csum.sv
module kline_csum #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         add,
   input  logic [W-1:0] din,
   output logic [W-1:0] sum
);
   generate
      if (W < 1) begin : g_bad_w
         $error("kline_csum: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc_q <= '0;
      else if (clr) acc_q <= '0;
      else if (add) acc_q <= acc_q + din;
   end

   assign sum = acc_q;
endmodule

// File: rtl/kline_seg_buf.sv
module kline_seg_buf #(
   parameter int W     = 8,
   parameter int DEPTH = 15,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [W-1:0]     wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [W-1:0]     rd_data
);
   generate
      if (DEPTH < 1 || (1 << IDX_W) < DEPTH) begin : g_bad_depth
         $error("kline_seg_buf: DEPTH does not fit IDX_W");
      end
   endgenerate

   logic [DEPTH*W-1:0] flat;

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic [W-1:0] ent_q;
      always_ff @(posedge clk) begin
         if (wr_en && wr_idx == IDX_W'(g)) ent_q <= wr_data;
      end
      assign flat[g*W +: W] = ent_q;
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (rd_idx == IDX_W'(i)) rd_data = flat[i*W +: W];
      end
   end
endmodule

// File: rtl/kline_echo_timer.sv
module kline_echo_timer #(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             kick,
   input  logic [TMO_W-1:0] limit,
   output logic             expired
);
   generate
      if (TMO_W < 1) begin : g_bad_w
         $error("kline_echo_timer: TMO_W must be at least 1");
      end
   endgenerate

   logic [TMO_W-1:0] cnt_q;
   logic [TMO_W-1:0] lim;

   assign lim     = (limit == '0) ? TMO_W'(1) : limit;
   assign expired = run && !kick && (cnt_q == lim - TMO_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!run || kick)   cnt_q <= '0;
      else if (!expired)       cnt_q <= cnt_q + TMO_W'(1);
   end

   AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q < lim)); // R9
endmodule

// File: rtl/kline_seg_tx.sv
module kline_seg_tx
   import kline_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int LEN_W   = 8,
   parameter int SEG_MAX = 15,
   parameter int TMO_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [LEN_W-1:0]  msg_len,
   input  logic [TMO_W-1:0]  echo_timeout,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   input  logic              tx_ready,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              busy,
   output logic              done,
   output logic              echo_err
);
   localparam int SEG_W = $clog2(SEG_MAX + 1);

   generate
      if (SEG_MAX < 1) begin : g_bad_seg
         $error("kline_seg_tx: SEG_MAX must be at least 1");
      end
      if (LEN_W < 1 || DATA_W < 1) begin : g_bad_w
         $error("kline_seg_tx: widths must be positive");
      end
   endgenerate

   kl_state_e          state_q;
   logic [LEN_W-1:0]   len_q;
   logic [LEN_W-1:0]   pay_cnt_q;
   logic [SEG_W-1:0]   seg_cnt_q;
   logic [SEG_W-1:0]   echo_idx_q;
   logic               frame_end_q;
   logic               err_q;

   logic               accept;
   logic               ck_phase;
   logic               tx_fire;
   logic               rx_fire;
   logic               seg_full;
   logic               echo_last;
   logic               mismatch;
   logic               tmo_hit;
   logic [DATA_W-1:0]  ck_sum;
   logic [DATA_W-1:0]  sent_byte;

   assign accept    = (state_q == KL_IDLE) && start && (msg_len != '0);
   assign ck_phase  = (pay_cnt_q == len_q);

   // Edge handshakes
   assign tx_valid  = (state_q == KL_SEND) && (ck_phase || in_valid);
   assign tx_data   = ck_phase ? ck_sum : in_data;
   assign in_ready  = (state_q == KL_SEND) && !ck_phase && tx_ready;
   assign rx_ready  = (state_q == KL_DRAIN) || (state_q == KL_ECHO);
   assign tx_fire   = tx_valid && tx_ready;
   assign rx_fire   = rx_valid && rx_ready;

   assign seg_full  = (seg_cnt_q == SEG_W'(SEG_MAX - 1));
   assign echo_last = (echo_idx_q == seg_cnt_q - SEG_W'(1));
   assign mismatch  = (rx_data != sent_byte);

   assign busy      = (state_q == KL_DRAIN) || (state_q == KL_SEND) || (state_q == KL_ECHO);
   assign done      = (state_q == KL_DONE);
   assign echo_err  = err_q;

   kline_csum #(.W(DATA_W)) u_csum (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (accept),
      .add   (tx_fire && !ck_phase),
      .din   (in_data),
      .sum   (ck_sum)
   );

   kline_seg_buf #(.W(DATA_W), .DEPTH(SEG_MAX), .IDX_W(SEG_W)) u_buf (
      .clk     (clk),
      .wr_en   (tx_fire),
      .wr_idx  (seg_cnt_q),
      .wr_data (tx_data),
      .rd_idx  (echo_idx_q),
      .rd_data (sent_byte)
   );

   kline_echo_timer #(.TMO_W(TMO_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state_q == KL_ECHO),
      .kick    (rx_valid),
      .limit   (echo_timeout),
      .expired (tmo_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= KL_IDLE;
         len_q       <= '0;
         pay_cnt_q   <= '0;
         seg_cnt_q   <= '0;
         echo_idx_q  <= '0;
         frame_end_q <= 1'b0;
         err_q       <= 1'b0;
      end else begin
         unique case (state_q)
            KL_IDLE: begin
               if (accept) begin
                  len_q       <= msg_len;
                  pay_cnt_q   <= '0;
                  seg_cnt_q   <= '0;
                  echo_idx_q  <= '0;
                  frame_end_q <= 1'b0;
                  err_q       <= 1'b0;
                  state_q     <= KL_DRAIN;
               end
            end
            KL_DRAIN: begin
               if (!rx_valid) state_q <= KL_SEND;
            end
            KL_SEND: begin
               if (tx_fire) begin
                  seg_cnt_q <= seg_cnt_q + SEG_W'(1);
                  if (!ck_phase) pay_cnt_q <= pay_cnt_q + LEN_W'(1);
                  if (ck_phase || seg_full) begin
                     frame_end_q <= ck_phase;
                     echo_idx_q  <= '0;
                     state_q     <= KL_ECHO;
                  end
               end
            end
            KL_ECHO: begin
               if (rx_fire) begin
                  if (mismatch) begin
                     err_q   <= 1'b1;
                     state_q <= KL_DONE;
                  end else if (echo_last) begin
                     seg_cnt_q <= '0;
                     state_q   <= frame_end_q ? KL_DONE : KL_SEND;
                  end else begin
                     echo_idx_q <= echo_idx_q + SEG_W'(1);
                  end
               end else if (tmo_hit) begin
                  err_q   <= 1'b1;
                  state_q <= KL_DONE;
               end
            end
            KL_DONE: state_q <= KL_IDLE;
            default: state_q <= KL_IDLE;
         endcase
      end
   end

   AST_SEG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      tx_fire |-> (seg_cnt_q < SEG_W'(SEG_MAX))); // R2
   AST_NO_TX_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ready && busy) |-> !tx_valid); // R3
   AST_ERR_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(echo_err) |-> done); // R4
   AST_DRAIN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (rx_ready && !tx_valid)); // R5
   AST_NO_FEED_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready |-> !in_ready); // R6
   AST_PAY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (pay_cnt_q <= len_q)); // R6
   AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(len_q)); // R7
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (echo_err && !accept) |=> echo_err); // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R12
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R12
endmodule

// File: tb/kline_seg_tx_test.sv
module kline_seg_tx_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  msg_len = 8'd0;
   logic [15:0] echo_timeout = 16'd40;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = 8'd0;
   logic        in_ready;
   logic        tx_valid;
   logic [7:0]  tx_data;
   logic        tx_ready = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = 8'd0;
   logic        rx_ready;
   logic        busy;
   logic        done;
   logic        echo_err;

   always #2.5 clk = ~clk;

   kline_seg_tx uut (
      .clk(clk), .rst_n(rst_n), .start(start), .msg_len(msg_len),
      .echo_timeout(echo_timeout), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_ready(rx_ready), .busy(busy), .done(done), .echo_err(echo_err)
   );

   int checks = 0;
   int fails  = 0;

   // Environment model state
   logic [7:0] msg [256];
   logic [7:0] sent [300];
   logic [7:0] echo_q [$];
   int  tx_cnt = 0, pending = 0, junk_left = 0, seq_bad = 0;
   int  feed_idx = 0, feed_len = 0, done_cnt = 0, cyc = 0;
   int  corrupt_at = -1, drop_from = -1;
   bit  stall = 1'b0, env_on = 1'b0;
   bit  tx_took = 1'b0, rx_took = 1'b0, in_took = 1'b0;
   logic [7:0] tx_byte = 8'd0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Transmitter sink, loop-back echo, receive queue and payload source
   initial begin
      forever begin
         @(negedge clk);
         if (rx_took) begin
            if (echo_q.size() > 0) echo_q.delete(0);
            if (junk_left > 0) junk_left--;
            else pending--;
         end
         if (tx_took) begin
            if (pending != (tx_cnt % 15)) seq_bad++;
            if (tx_cnt < 300) sent[tx_cnt] = tx_byte;
            if (drop_from < 0 || tx_cnt < drop_from)
               echo_q.push_back((tx_cnt == corrupt_at) ? (tx_byte ^ 8'hFF) : tx_byte);
            tx_cnt++;
            pending++;
         end
         if (in_took) feed_idx++;
         cyc++;
         rx_valid = env_on && (echo_q.size() > 0);
         rx_data  = (echo_q.size() > 0) ? echo_q[0] : 8'd0;
         tx_ready = env_on && (stall ? cyc[0] : 1'b1);
         in_valid = env_on && (feed_idx < feed_len);
         in_data  = msg[feed_idx[7:0]];
         #1;
         tx_took = tx_valid && tx_ready;
         tx_byte = tx_data;
         rx_took = rx_valid && rx_ready;
         in_took = in_valid && in_ready;
         if (done) done_cnt++;
      end
   end

   initial begin
      int wd = 0;
      forever begin
         @(posedge clk);
         wd++;
         if (wd > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
         end
      end
   end

   // One frame: returns nothing, checks everything
   task automatic run_frame(input int len, input int seed, input int junk,
                            input int c_at, input int d_from, input bit stl,
                            input bit disturb, input int exp_sent, input bit exp_err,
                            input string name);
      int ck = 0;
      int bad = 0;
      int exp_pay;
      for (int i = 0; i < 256; i++) msg[i] = 8'((seed * 37 + i * i * 13 + i * 5) & 255);
      if (seed < 0) for (int i = 0; i < 256; i++) msg[i] = 8'hFF;
      for (int i = 0; i < len; i++) ck = (ck + msg[i]) % 256;
      @(negedge clk);
      #2;
      env_on = 1'b0;
      echo_q.delete();
      for (int i = 0; i < junk; i++) echo_q.push_back(8'(8'hA5 + i));
      junk_left = junk; tx_cnt = 0; pending = 0; seq_bad = 0;
      feed_idx = 0; feed_len = len; done_cnt = 0;
      corrupt_at = c_at; drop_from = d_from; stall = stl;
      env_on = 1'b1;
      start = 1'b1; msg_len = 8'(len);
      @(negedge clk);
      #2;
      start = 1'b0;
      // R8: accepted start clears the error flag
      chk(echo_err == 1'b0, {name, " R8 cleared at start"}, echo_err, 0);
      chk(busy == 1'b1, {name, " R12 busy after start"}, busy, 1);
      if (disturb) begin
         repeat (6) @(negedge clk);
         #2;
         msg_len = 8'd3;          // R7: must not change running frame
         start = 1'b1;            // R10: ignored while busy
         @(negedge clk);
         #2;
         start = 1'b0;
      end
      for (int i = 0; i < 20000 && done_cnt == 0; i++) @(negedge clk);
      repeat (4) @(negedge clk);
      #2;
      chk(done_cnt == 1, {name, " R12 one done pulse"}, done_cnt, 1);
      chk(busy == 1'b0, {name, " R12 idle after done"}, busy, 0);
      chk(tx_cnt == exp_sent, {name, " R2/R4 bytes sent"}, tx_cnt, exp_sent);
      for (int i = 0; i < tx_cnt && i < 300; i++)
         if (sent[i] != ((i < len) ? msg[i] : 8'(ck))) bad++;
      chk(bad == 0, {name, " R1 byte values and checksum"}, bad, 0);
      chk(seq_bad == 0, {name, " R3 segment waits for echo"}, seq_bad, 0);
      chk(echo_err == exp_err, {name, " R4/R9 error flag"}, echo_err, exp_err);
      exp_pay = (exp_sent > len) ? len : exp_sent;
      chk(feed_idx == exp_pay, {name, " R6 payload bytes taken"}, feed_idx, exp_pay);
      chk(junk_left == 0, {name, " R5 stale bytes drained"}, junk_left, 0);
      env_on = 1'b0;
   endtask

   task automatic test_reset();
      #1;
      chk(busy == 1'b0 && done == 1'b0 && echo_err == 1'b0, "R11 reset flags", busy + done + echo_err, 0);
      chk(tx_valid == 1'b0 && in_ready == 1'b0 && rx_ready == 1'b0, "R11 reset handshakes",
          tx_valid + in_ready + rx_ready, 0);
   endtask

   task automatic test_zero_len();
      @(negedge clk);
      #2;
      start = 1'b1; msg_len = 8'd0;
      @(negedge clk);
      #2;
      start = 1'b0;
      chk(busy == 1'b0, "R10 zero length start ignored", busy, 0);
      repeat (3) @(negedge clk);
      #2;
      chk(tx_valid == 1'b0 && done == 1'b0, "R10 no output after zero length", tx_valid + done, 0);
   endtask

   task automatic test_sticky();
      repeat (10) @(negedge clk);
      #2;
      chk(echo_err == 1'b1, "R8 error held while idle", echo_err, 1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      echo_timeout = 16'd40;
      run_frame(5,   1, 0, -1, -1, 1'b0, 1'b0, 6,   1'b0, "short");
      run_frame(3,  -1, 0, -1, -1, 1'b0, 1'b0, 4,   1'b0, "wrap");
      run_frame(14,  2, 0, -1, -1, 1'b1, 1'b0, 15,  1'b0, "one_full_seg");
      run_frame(15,  3, 0, -1, -1, 1'b0, 1'b0, 16,  1'b0, "seg_plus_one");
      run_frame(255, 4, 0, -1, -1, 1'b1, 1'b0, 256, 1'b0, "longest");
      run_frame(20,  5, 3, -1, -1, 1'b0, 1'b0, 21,  1'b0, "drain");
      run_frame(20,  6, 0, 3,  -1, 1'b0, 1'b0, 15,  1'b1, "bad_echo_first");
      test_sticky();
      run_frame(20,  7, 0, 18, -1, 1'b0, 1'b0, 21,  1'b1, "bad_echo_last");
      run_frame(20,  8, 0, -1, 5,  1'b0, 1'b0, 15,  1'b1, "echo_timeout");
      test_sticky();
      echo_timeout = 16'd2;
      run_frame(30,  9, 0, -1, -1, 1'b1, 1'b0, 31,  1'b0, "short_timeout_ok");
      echo_timeout = 16'd40;
      run_frame(40, 10, 0, -1, -1, 1'b0, 1'b1, 41,  1'b0, "disturb");
      test_zero_len();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule